// File: doc/BRIEF.md
# Serial Step-Attenuator Write Controller

This block sits on the host side of a digitally stepped RF attenuator and sends it a 5-bit attenuation code over a three-wire link. The three wires are serial data, serial clock and a latch strobe. A one-cycle start request carries the new code. The block builds a 6-bit word that begins with a mandatory zero start bit, followed by the code from its heaviest weight (8 dB) down to its lightest (0.5 dB). It shifts the word out most significant bit first, then pulses the latch strobe so that the attenuator takes the word.

Every analog timing minimum of the link is a parameter counted in system clock cycles, rounded up from its nanosecond figure. These minimums are: clock high and low phases, data setup before the rising clock edge, data hold after the falling clock edge, the delay from the last falling edge to the latch, and the latch pulse width. A further parameter sets the minimum spacing between two attenuation writes (40 µs by default at a 5 ns system clock).

Requests that arrive while a write is in progress, or before that spacing has run out, are held and served later. Only the newest code is kept. The block reports a write in progress on `busy_o` and its completion on a one-cycle `done_o`.

Top module: `atten_serial_master`

## Requirements
- R1: Each write carries exactly 6 bits, sampled on rising serial-clock edges. The first bit is 0, and the next five are value bits 4 down to 0 (bit 4 weighs 8 dB, bit 0 weighs 0.5 dB) of the request being served.
- R2: The serial clock idles low. Each high phase lasts at least CLK_HI_CYC cycles. Between a falling edge and the next rising edge it stays low for at least CLK_LO_CYC cycles.
- R3: Serial data changes only while the serial clock is low. It is stable for at least SETUP_CYC cycles before each rising edge, and it stays unchanged for at least HOLD_CYC cycles after each falling edge.
- R4: The latch is low whenever the serial clock is high and throughout shifting. It rises only after all 6 bits, at least LE_SETUP_CYC cycles after the last falling clock edge, and it stays high for at least LE_WIDTH_CYC cycles.
- R5: Two successive rising latch edges are at least MIN_GAP_CYC cycles apart.
- R6: A start request made while a write is in progress, or inside the spacing window, is kept and served later. Of several such requests only the newest value is written, and no request is lost.
- R7: `done_o` is high for exactly one cycle: the first cycle in which the latch is low again. `busy_o` is high from the cycle after a request is accepted, for the whole write including the latch pulse, and is low in the `done_o` cycle.
- R8: While reset is asserted, and until a request arrives after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to write `value_i` |
| value_i | input | 5 | Attenuation code, bit 4 = 8 dB down to bit 0 = 0.5 dB |
| ser_data_o | output | 1 | Serial data to the attenuator |
| ser_clk_o | output | 1 | Serial clock to the attenuator |
| latch_o | output | 1 | Latch strobe to the attenuator |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle pulse when a write has completed |

## Verification
The bench builds the block with short timing counts: high 3, low 4, setup 2, hold 1, latch setup 2, latch width 3, and spacing 80. With these values the low phase comes from the clock-low minimum rather than from setup plus hold, one write lasts well under the spacing window, and some hundred writes fit in a short run. Requests that arrive in back-to-back cycles, during a write, and inside the spacing window all occur, so the pending path and its newest-value rule are exercised repeatedly. A monitor on the three wires measures every phase against its minimum and decodes every word.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD,
    PH_LEWAIT,
    PH_LATCH
  } phase_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/atten_req_hold.sv
module atten_req_hold #(
  parameter int unsigned VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic             accept_i,
  output logic             pend_o,
  output logic [VAL_W-1:0] value_o
);
  logic             pend_q, pend_d;
  logic [VAL_W-1:0] val_q, val_d;

  always_comb begin
    pend_d = pend_q;
    val_d  = val_q;
    if (accept_i) pend_d = 1'b0;
    if (start_i) begin
      pend_d = 1'b1;
      val_d  = value_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      val_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (start_i) val_q <= val_d;
    end
  end

  assign pend_o  = pend_q;
  assign value_o = val_q;

  assert_start_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pend_o && value_o == $past(value_i)));
endmodule

// File: rtl/atten_gap_timer.sv
module atten_gap_timer #(
  parameter int unsigned GAP_CYC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = CW'(GAP_CYC - 1);
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == '0);

  assert_no_early_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !ready_o || (GAP_CYC <= 1));
endmodule

// File: rtl/atten_frame_shifter.sv
module atten_frame_shifter
  import atten_ser_pkg::*;
#(
  parameter int unsigned VAL_W     = 5,
  parameter int unsigned HI_CYC    = 6,
  parameter int unsigned LOWB_CYC  = 4,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned LESU_CYC  = 2,
  parameter int unsigned LEW_CYC   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             ser_clk_o,
  output logic             ser_data_o,
  output logic             latch_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned FW     = VAL_W + 1;
  localparam int unsigned BW     = $clog2(FW);
  localparam int unsigned MAXLEN = umax(umax(umax(HI_CYC, LOWB_CYC), umax(HOLD_CYC, LESU_CYC)), LEW_CYC);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bidx_q, bidx_d;
  logic [FW-1:0] frm_q, frm_d;
  logic          adv;
  logic          sclk_q, sdat_q, le_q, done_q;
  logic          shifting_d;

  assign adv = (ph_q != PH_IDLE) || go_i;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q - CW'(1);
    bidx_d = bidx_q;
    frm_d  = frm_q;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (go_i) begin
          frm_d  = {1'b0, value_i};
          bidx_d = BW'(FW - 1);
          ph_d   = PH_SETUP;
          cnt_d  = CW'(LOWB_CYC - 1);
        end
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_d  = PH_HIGH;
        cnt_d = CW'(HI_CYC - 1);
      end
      PH_HIGH: if (cnt_q == '0) begin
        ph_d  = PH_HOLD;
        cnt_d = CW'(HOLD_CYC - 1);
      end
      PH_HOLD: if (cnt_q == '0) begin
        if (bidx_q == '0) begin
          ph_d  = PH_LEWAIT;
          cnt_d = CW'(LESU_CYC - 1);
        end else begin
          ph_d   = PH_SETUP;
          bidx_d = bidx_q - BW'(1);
          cnt_d  = CW'(LOWB_CYC - 1);
        end
      end
      PH_LEWAIT: if (cnt_q == '0) begin
        ph_d  = PH_LATCH;
        cnt_d = CW'(LEW_CYC - 1);
      end
      PH_LATCH: if (cnt_q == '0) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign shifting_d = (ph_d == PH_SETUP) || (ph_d == PH_HIGH) || (ph_d == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      frm_q  <= '0;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
      le_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (adv) begin
        ph_q   <= ph_d;
        cnt_q  <= cnt_d;
        bidx_q <= bidx_d;
        frm_q  <= frm_d;
      end
      sclk_q <= (ph_d == PH_HIGH);
      sdat_q <= shifting_d ? frm_d[bidx_d] : 1'b0;
      le_q   <= (ph_d == PH_LATCH);
      done_q <= (ph_q == PH_LATCH) && (ph_d != PH_LATCH);
    end
  end

  assign ser_clk_o  = sclk_q;
  assign ser_data_o = sdat_q;
  assign latch_o    = le_q;
  assign done_o     = done_q;
  assign busy_o     = (ph_q != PH_IDLE);

  assert_data_still_while_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));
  assert_latch_clock_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> !ser_clk_o);
  assert_done_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(latch_o) && !latch_o && !busy_o));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_busy_in_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> busy_o);
endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import atten_ser_pkg::*;
#(
  parameter int unsigned VAL_W        = 5,
  parameter int unsigned CLK_HI_CYC   = 6,
  parameter int unsigned CLK_LO_CYC   = 6,
  parameter int unsigned SETUP_CYC    = 2,
  parameter int unsigned HOLD_CYC     = 2,
  parameter int unsigned LE_SETUP_CYC = 2,
  parameter int unsigned LE_WIDTH_CYC = 6,
  parameter int unsigned MIN_GAP_CYC  = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             ser_data_o,
  output logic             ser_clk_o,
  output logic             latch_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned LOW_REST = (CLK_LO_CYC > HOLD_CYC) ? (CLK_LO_CYC - HOLD_CYC) : 1;
  localparam int unsigned LOWB_CYC = umax(SETUP_CYC, LOW_REST);

  logic             rs1_q, rs2_q, rst_int_n;
  logic             pend, ready, accept, busy;
  logic [VAL_W-1:0] pend_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  assign accept = pend && ready && !busy;

  atten_req_hold #(.VAL_W(VAL_W)) i_hold (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .value_i(value_i),
    .accept_i(accept), .pend_o(pend), .value_o(pend_val)
  );

  atten_gap_timer #(.GAP_CYC(MIN_GAP_CYC)) i_gap (
    .clk(clk), .rst_n(rst_int_n), .load_i(accept), .ready_o(ready)
  );

  atten_frame_shifter #(
    .VAL_W(VAL_W), .HI_CYC(CLK_HI_CYC), .LOWB_CYC(LOWB_CYC),
    .HOLD_CYC(HOLD_CYC), .LESU_CYC(LE_SETUP_CYC), .LEW_CYC(LE_WIDTH_CYC)
  ) i_shift (
    .clk(clk), .rst_n(rst_int_n), .go_i(accept), .value_i(pend_val),
    .ser_clk_o(ser_clk_o), .ser_data_o(ser_data_o), .latch_o(latch_o),
    .busy_o(busy), .done_o(done_o)
  );

  assign busy_o = busy;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (!ser_clk_o && !latch_o && !ser_data_o));
endmodule

// File: tb/test_atten_serial_master.sv
`timescale 1ns/1ps
module test_atten_serial_master;
  localparam int HI = 3, LO = 4, SU = 2, HO = 1, LESU = 2, LEW = 3, GAP = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] value_i = '0;
  logic       ser_data_o, ser_clk_o, latch_o, busy_o, done_o;

  atten_serial_master #(
    .CLK_HI_CYC(HI), .CLK_LO_CYC(LO), .SETUP_CYC(SU), .HOLD_CYC(HO),
    .LE_SETUP_CYC(LESU), .LE_WIDTH_CYC(LEW), .MIN_GAP_CYC(GAP)
  ) i_atten_serial_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
    .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .latch_o(latch_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      wrap_up();
    end
  end

  // bench-side record of the newest requested value, one edge behind
  logic [4:0] pv = '0, pv_old = '0;
  always @(posedge clk) begin
    pv_old <= pv;
    if (start_i) pv <= value_i;
  end

  // wire monitor
  bit   mon_en = 0;
  logic p_clk = 0, p_dat = 0, p_le = 0, p_busy = 0;
  int   since_fall = 0, dstab = 0, hi_run = 0, le_run = 0, le_gap = 0, bitcnt = 0;
  int   frames = 0;
  logic [5:0] bits = '0;
  logic [4:0] exp_val = '0, last_val = '0;

  always @(negedge clk) if (mon_en) begin
    le_gap++;
    if (busy_o && !p_busy) begin
      exp_val = pv_old;
      bitcnt  = 0;
    end
    if (ser_data_o != p_dat) begin
      chk(!ser_clk_o && !p_clk, "R3 data moved with clock high", ser_clk_o, 0);
      if (bitcnt > 0) chk(since_fall >= HO, "R3 hold", since_fall, HO);
      dstab = 1;
    end else dstab++;
    if (ser_clk_o && !p_clk) begin
      if (bitcnt > 0) chk(since_fall >= LO, "R2 low phase", since_fall, LO);
      chk(dstab - 1 >= SU, "R3 setup", dstab - 1, SU);
      chk(!latch_o, "R4 latch low in shift", latch_o, 0);
      bits = {bits[4:0], ser_data_o};
      bitcnt++;
    end
    if (ser_clk_o) hi_run++;
    if (!ser_clk_o && p_clk) begin
      chk(hi_run >= HI, "R2 high phase", hi_run, HI);
      hi_run = 0;
    end
    if (latch_o && !p_le) begin
      chk(bitcnt == 6, "R4 bits before latch", bitcnt, 6);
      chk(since_fall >= LESU, "R4 latch setup", since_fall, LESU);
      if (frames > 0) chk(le_gap >= GAP, "R5 update spacing", le_gap, GAP);
      le_gap = 0;
      le_run = 0;
    end
    if (latch_o) begin
      le_run++;
      if (!busy_o) chk(0, "R7 busy during latch", busy_o, 1);
    end
    if (!latch_o && p_le) begin
      chk(le_run >= LEW, "R4 latch width", le_run, LEW);
      chk(done_o == 1'b1, "R7 done with latch fall", done_o, 1);
      chk(busy_o == 1'b0, "R7 busy low at done", busy_o, 0);
      chk(bits == {1'b0, exp_val}, "R1 frame word", bits, {1'b0, exp_val});
      frames++;
      last_val = bits[4:0];
    end else if (done_o) chk(0, "R7 stray done", done_o, 0);
    if (!ser_clk_o && p_clk) since_fall = 1;
    else since_fall++;
    p_clk = ser_clk_o; p_dat = ser_data_o; p_le = latch_o; p_busy = busy_o;
  end

  task automatic req(input logic [4:0] v);
    @(posedge clk); #1;
    start_i = 1'b1; value_i = v;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  logic [4:0] last_req;
  int frames_before;

  initial begin
    void'($urandom(32'h00C0FFEE));
    idle_cycles(3);
    @(negedge clk);
    chk({ser_data_o, ser_clk_o, latch_o, busy_o, done_o} == 5'b0, "R8 reset outputs",
        {ser_data_o, ser_clk_o, latch_o, busy_o, done_o}, 0);
    #1 rst_n = 1'b1;
    idle_cycles(6);
    @(negedge clk);
    chk({ser_data_o, ser_clk_o, latch_o, busy_o, done_o} == 5'b0, "R8 idle after reset",
        {ser_data_o, ser_clk_o, latch_o, busy_o, done_o}, 0);
    mon_en = 1;

    // R1: extreme codes
    req(5'h1F); idle_cycles(200);
    req(5'h00); idle_cycles(200);
    req(5'h10); idle_cycles(200);
    chk(frames == 3, "R1 three single writes", frames, 3);

    // R6: requests during a write, newest wins
    frames_before = frames;
    req(5'h13); idle_cycles(2);
    req(5'h0A);
    req(5'h15);
    idle_cycles(300);
    chk(frames - frames_before == 2, "R6 two writes served", frames - frames_before, 2);
    chk(last_val == 5'h15, "R6 newest value written", last_val, 5'h15);

    // R5/R6: request inside the spacing window after a write ends
    req(5'h07); idle_cycles(60);
    req(5'h18); idle_cycles(300);
    chk(last_val == 5'h18, "R6 window request served", last_val, 5'h18);

    // random mix
    for (int n = 0; n < 60; n++) begin
      last_req = 5'($urandom_range(0, 31));
      req(last_req);
      idle_cycles($urandom_range(0, 150));
    end
    idle_cycles(400);
    @(negedge clk);
    chk(!busy_o, "R7 idle at end", busy_o, 0);
    chk(last_val == last_req, "R6 final value", last_val, last_req);
    wrap_up();
  end
endmodule